// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Line Controller

This block looks after a bank of up to 32 I/O lines. Software can own each line as a general-purpose pin, driving its output value and output enable from registers. It can also hand the line to one of two on-chip peripheral functions, called A and B, which then drive the pad directly. A pull-up control is kept for every line. The current pad level can always be read back.

Software reaches the block over a small single-cycle register bus. Writes take effect at the next clock edge. Read data is combinational from the address. The mode, output-enable, output-data and pull-up controls each have a pair of write addresses, one that sets bits and one that clears bits, plus a read-only status address. Function selection has a pair too: a 1 written to the B address selects B, and a 1 written to the A address selects A. Bits written as 0 never change anything.

The reset state is chosen per line by two parameters. A line whose bit in `RST_PERIPH` is 1 leaves reset owned by a peripheral (function B if its `RST_SEL_B` bit is 1, otherwise A), so it drives the pad immediately. Every other line leaves reset as a pulled-up input. Pull-ups are enabled on all lines at reset.

Top module: `gpio_mux`

Register word addresses: 0 mode set, 1 mode clear, 2 mode status (1 = peripheral), 3 select A, 4 select B, 5 select status (1 = B), 6 OE set, 7 OE clear, 8 OE status, 9 data set, 10 data clear, 11 data status, 12 pull-up set, 13 pull-up clear, 14 pull-up status, 15 pin level.

## Requirements
- R1: During and straight after reset, mode status reads `RST_PERIPH`, select status reads `RST_SEL_B`, OE and data status read 0, and pull-up status reads all ones.
- R2: From the first cycle after reset, a line that resets in peripheral mode has `pad_out`/`pad_oe` equal to the outputs of its reset-selected function.
- R3: A write to address 0 sets, and a write to address 1 clears, exactly the mode bits written as 1. Other bits keep their values, and the change is visible the next cycle.
- R4: A write to address 4 selects function B, and a write to address 3 selects function A, for exactly the bits written as 1.
- R5: For a line in general-purpose mode, `pad_out` and `pad_oe` follow the data and OE registers, which have set/clear/status addresses 9..11 and 6..8.
- R6: For a line in peripheral mode, `pad_out` and `pad_oe` come from the selected function. Writes to the data or OE registers still update their status but do not reach the pad.
- R7: Pull-up set (12) and clear (13) act per bit, and `pad_pu` always equals the pull-up status.
- R8: Address 15 returns `pad_in` in any mode. The set and clear addresses read as 0.
- R9: `pa_in` carries `pad_in` for lines assigned to function A and is 0 elsewhere. `pb_in` does the same for lines assigned to function B.
- R10: Writes to the status addresses (2, 5, 8, 11, 14, 15) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pa_out | input | NLINES | Function A output values |
| pa_oe | input | NLINES | Function A output enables |
| pa_in | output | NLINES | Pad level delivered to function A |
| pb_out | input | NLINES | Function B output values |
| pb_oe | input | NLINES | Function B output enables |
| pb_in | output | NLINES | Pad level delivered to function B |
| pad_out | output | NLINES | Pad output value |
| pad_oe | output | NLINES | Pad output enable |
| pad_in | input | NLINES | Pad input level |
| pad_pu | output | NLINES | Pull-up enable per pad |

## Verification
Two things can happen in the same cycle: a write that moves lines between general-purpose and peripheral ownership, or between A and B, and a change on the peripheral or pad inputs. The bench makes these coincide on purpose. It toggles the function signals and `pad_in` in the very cycles that carry mode, select and data writes, and it keeps doing so through a long run of mixed writes. A behavioural reference model is updated at each edge. Every pad, function-input and read output is compared with it on every cycle, so a route that switches a cycle early or late, or that uses the old owner, is caught.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int ADDR_W = 4;
    localparam int BUS_W  = 32;
    localparam int NREGS  = 5;

    // Index of each set/clear register in the register bank
    localparam int IDX_MODE = 0;
    localparam int IDX_FSEL = 1;
    localparam int IDX_OE   = 2;
    localparam int IDX_OUT  = 3;
    localparam int IDX_PU   = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE_SET  = 4'd0,
        ADR_MODE_CLR  = 4'd1,
        ADR_MODE_STAT = 4'd2,
        ADR_FSEL_A    = 4'd3,
        ADR_FSEL_B    = 4'd4,
        ADR_FSEL_STAT = 4'd5,
        ADR_OE_SET    = 4'd6,
        ADR_OE_CLR    = 4'd7,
        ADR_OE_STAT   = 4'd8,
        ADR_OUT_SET   = 4'd9,
        ADR_OUT_CLR   = 4'd10,
        ADR_OUT_STAT  = 4'd11,
        ADR_PU_SET    = 4'd12,
        ADR_PU_CLR    = 4'd13,
        ADR_PU_STAT   = 4'd14,
        ADR_PIN_STAT  = 4'd15
    } reg_addr_e;
endpackage

// File: rtl/gpio_sc_reg.sv
// One per-line control word written through separate set and clear strobes
module gpio_sc_reg #(
    parameter int               W   = 32,
    parameter logic [W-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (set_en) begin
            q <= q | wdata;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/gpio_reg_decode.sv
// Write strobe decode and read-back multiplexer
module gpio_reg_decode
    import gpio_mux_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [NREGS-1:0][NLINES-1:0]  regs_q,
    input  logic [NLINES-1:0]             pad_in,
    output logic [NREGS-1:0]              set_en,
    output logic [NREGS-1:0]              clr_en,
    output logic [BUS_W-1:0]              bus_rdata
);
    reg_addr_e adr;
    assign adr = reg_addr_e'(bus_addr);

    always_comb begin
        set_en = '0;
        clr_en = '0;
        if (bus_wr) begin
            unique case (adr)
                ADR_MODE_SET: set_en[IDX_MODE] = 1'b1;
                ADR_MODE_CLR: clr_en[IDX_MODE] = 1'b1;
                ADR_FSEL_B:   set_en[IDX_FSEL] = 1'b1;
                ADR_FSEL_A:   clr_en[IDX_FSEL] = 1'b1;
                ADR_OE_SET:   set_en[IDX_OE]   = 1'b1;
                ADR_OE_CLR:   clr_en[IDX_OE]   = 1'b1;
                ADR_OUT_SET:  set_en[IDX_OUT]  = 1'b1;
                ADR_OUT_CLR:  clr_en[IDX_OUT]  = 1'b1;
                ADR_PU_SET:   set_en[IDX_PU]   = 1'b1;
                ADR_PU_CLR:   clr_en[IDX_PU]   = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (adr)
            ADR_MODE_STAT: bus_rdata[NLINES-1:0] = regs_q[IDX_MODE];
            ADR_FSEL_STAT: bus_rdata[NLINES-1:0] = regs_q[IDX_FSEL];
            ADR_OE_STAT:   bus_rdata[NLINES-1:0] = regs_q[IDX_OE];
            ADR_OUT_STAT:  bus_rdata[NLINES-1:0] = regs_q[IDX_OUT];
            ADR_PU_STAT:   bus_rdata[NLINES-1:0] = regs_q[IDX_PU];
            ADR_PIN_STAT:  bus_rdata[NLINES-1:0] = pad_in;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_pad_route.sv
// Per-line choice of pad driver and gating of function inputs
module gpio_pad_route #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] periph,
    input  logic [NLINES-1:0] sel_b,
    input  logic [NLINES-1:0] sw_out,
    input  logic [NLINES-1:0] sw_oe,
    input  logic [NLINES-1:0] pa_out,
    input  logic [NLINES-1:0] pa_oe,
    input  logic [NLINES-1:0] pb_out,
    input  logic [NLINES-1:0] pb_oe,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] pa_in,
    output logic [NLINES-1:0] pb_in
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic fn_out, fn_oe;
        assign fn_out     = sel_b[i] ? pb_out[i] : pa_out[i];
        assign fn_oe      = sel_b[i] ? pb_oe[i]  : pa_oe[i];
        assign pad_out[i] = periph[i] ? fn_out : sw_out[i];
        assign pad_oe[i]  = periph[i] ? fn_oe  : sw_oe[i];
        assign pa_in[i]   = pad_in[i] & periph[i] & ~sel_b[i];
        assign pb_in[i]   = pad_in[i] & periph[i] &  sel_b[i];
    end
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
    import gpio_mux_pkg::*;
#(
    parameter int                NLINES     = 32,
    parameter logic [NLINES-1:0] RST_PERIPH = '0,
    parameter logic [NLINES-1:0] RST_SEL_B  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pa_out,
    input  logic [NLINES-1:0] pa_oe,
    output logic [NLINES-1:0] pa_in,
    input  logic [NLINES-1:0] pb_out,
    input  logic [NLINES-1:0] pb_oe,
    output logic [NLINES-1:0] pb_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_pu
);
    localparam logic [NREGS-1:0][NLINES-1:0] RST_WORDS =
        {{NLINES{1'b1}}, {NLINES{1'b0}}, {NLINES{1'b0}}, RST_SEL_B, RST_PERIPH};

    logic [NREGS-1:0][NLINES-1:0] regs_q;
    logic [NREGS-1:0]             set_en, clr_en;

    gpio_reg_decode #(.NLINES(NLINES)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .regs_q    (regs_q),
        .pad_in    (pad_in),
        .set_en    (set_en),
        .clr_en    (clr_en),
        .bus_rdata (bus_rdata)
    );

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        gpio_sc_reg #(.W(NLINES), .RST(RST_WORDS[r])) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_en[r]),
            .clr_en (clr_en[r]),
            .wdata  (bus_wdata[NLINES-1:0]),
            .q      (regs_q[r])
        );
    end

    gpio_pad_route #(.NLINES(NLINES)) u_route (
        .periph  (regs_q[IDX_MODE]),
        .sel_b   (regs_q[IDX_FSEL]),
        .sw_out  (regs_q[IDX_OUT]),
        .sw_oe   (regs_q[IDX_OE]),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pa_in   (pa_in),
        .pb_in   (pb_in)
    );

    assign pad_pu = regs_q[IDX_PU];
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk
    import gpio_mux_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NLINES-1:0] pad_in,
    input logic [NLINES-1:0] mode_q,
    input logic [NLINES-1:0] fsel_q,
    input logic [NLINES-1:0] pu_q
);
    // R3
    mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MODE_SET) |=>
        ((mode_q & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

    // R3
    mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MODE_CLR) |=>
        ((mode_q & $past(bus_wdata[NLINES-1:0])) == '0));

    // R4
    fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == ADR_FSEL_A || bus_addr == ADR_FSEL_B)) |=> $stable(fsel_q));

    // R7
    pu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == ADR_PU_SET || bus_addr == ADR_PU_CLR)) |=> $stable(pu_q));

    // R10
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MODE_STAT) |=> $stable(mode_q));

    // R8
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_PIN_STAT) |-> (bus_rdata[NLINES-1:0] == pad_in));
endmodule

bind gpio_mux gpio_mux_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .mode_q    (regs_q[0]),
    .fsel_q    (regs_q[1]),
    .pu_q      (regs_q[4])
);

// File: tb/tb_gpio_mux.sv
`timescale 1ns/1ps
module tb_gpio_mux;
    localparam logic [31:0] RP = 32'h0000_00FF;
    localparam logic [31:0] RB = 32'h0000_00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0, pad_in = '0;
    logic [31:0] pa_in, pb_in, pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_mode, m_sel, m_oe, m_out, m_pu;

    always #5 clk = ~clk;

    gpio_mux #(.NLINES(32), .RST_PERIPH(RP), .RST_SEL_B(RB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in),
        .pb_out(pb_out), .pb_oe(pb_oe), .pb_in(pb_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = RP; m_sel = RB; m_oe = '0; m_out = '0; m_pu = '1;
        end else if (bus_wr) begin
            case (bus_addr)
                4'd0:  m_mode = m_mode | bus_wdata;
                4'd1:  m_mode = m_mode & ~bus_wdata;
                4'd3:  m_sel  = m_sel & ~bus_wdata;
                4'd4:  m_sel  = m_sel | bus_wdata;
                4'd6:  m_oe   = m_oe | bus_wdata;
                4'd7:  m_oe   = m_oe & ~bus_wdata;
                4'd9:  m_out  = m_out | bus_wdata;
                4'd10: m_out  = m_out & ~bus_wdata;
                4'd12: m_pu   = m_pu | bus_wdata;
                4'd13: m_pu   = m_pu & ~bus_wdata;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd2:  return m_mode;
            4'd5:  return m_sel;
            4'd8:  return m_oe;
            4'd11: return m_out;
            4'd14: return m_pu;
            4'd15: return pad_in;
            default: return '0;
        endcase
    endfunction

    function automatic string rd_req(input logic [3:0] a);
        case (a)
            4'd2:  return "R3";
            4'd5:  return "R4";
            4'd8, 4'd11: return "R5";
            4'd14: return "R7";
            default: return "R8";
        endcase
    endfunction

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] eo, ee;
            for (int i = 0; i < 32; i++) begin
                if (m_mode[i]) begin
                    eo[i] = m_sel[i] ? pb_out[i] : pa_out[i];
                    ee[i] = m_sel[i] ? pb_oe[i]  : pa_oe[i];
                end else begin
                    eo[i] = m_out[i];
                    ee[i] = m_oe[i];
                end
            end
            check("R5/R6", "pad_out", pad_out, eo);
            check("R5/R6", "pad_oe", pad_oe, ee);
            check("R7", "pad_pu", pad_pu, m_pu);
            check("R9", "pa_in", pa_in, pad_in & m_mode & ~m_sel);
            check("R9", "pb_in", pb_in, pad_in & m_mode & m_sel);
            check(rd_req(bus_addr), "bus_rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic drive_fn();
        pa_out = $urandom; pa_oe = $urandom;
        pb_out = $urandom; pb_oe = $urandom;
        pad_in = $urandom;
    endtask

    task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        drive_fn();
    endtask

    task automatic read_at(input logic [3:0] a, input logic [31:0] exp, input string req);
        cyc(1'b0, a, '0);
        @(negedge clk); #1;
        check(req, "read", bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive_fn();
        repeat (3) @(posedge clk);
        // R1: status reads while reset is still held
        @(negedge clk); #2; bus_addr = 4'd2;
        @(negedge clk); #1; check("R1", "mode during reset", bus_rdata, RP);
        #1 rst_n = 1'b1;
        // R2: peripheral lines drive on the first cycle after reset
        @(negedge clk); #1;
        check("R2", "pad_oe of reset-owned lines", pad_oe & RP, ((pb_oe & RB) | (pa_oe & ~RB)) & RP);
        check("R2", "pad_out of reset-owned lines", pad_out & RP, ((pb_out & RB) | (pa_out & ~RB)) & RP);
        read_at(4'd2, RP, "R1");
        read_at(4'd5, RB, "R1");
        read_at(4'd8, 32'h0, "R1");
        read_at(4'd11, 32'h0, "R1");
        read_at(4'd14, 32'hFFFF_FFFF, "R1");
        read_at(4'd1, 32'h0, "R8");
        // R3: set and clear of mode bits, mode writes coincide with input toggles
        cyc(1'b1, 4'd1, 32'h0000_00F0);
        cyc(1'b1, 4'd0, 32'h0000_0F00);
        read_at(4'd2, 32'h0000_0F0F, "R3");
        // R4: select B then A on a subset
        cyc(1'b1, 4'd4, 32'h0000_0C03);
        cyc(1'b1, 4'd3, 32'h0000_0001);
        read_at(4'd5, 32'h0000_0CF2, "R4");
        // R6: data/OE writes on peripheral lines reach status but not pad
        cyc(1'b1, 4'd9, 32'hFFFF_FFFF);
        cyc(1'b1, 4'd6, 32'hFFFF_FFFF);
        cyc(1'b0, 4'd11, '0);
        pa_oe = '0; pb_oe = '0;
        @(negedge clk); #1;
        check("R6", "pad_oe on peripheral lines", pad_oe & 32'h0000_0F0F, 32'h0);
        check("R5", "pad_oe on software lines", pad_oe & ~32'h0000_0F0F, ~32'h0000_0F0F);
        check("R6", "data status", bus_rdata, 32'hFFFF_FFFF);
        // R7: pull-up clear/set
        cyc(1'b1, 4'd13, 32'hA5A5_A5A5);
        cyc(1'b1, 4'd12, 32'h0000_0005);
        read_at(4'd14, 32'h5A5A_5A5F, "R7");
        // R10: writes to status addresses are ignored
        cyc(1'b1, 4'd2, 32'hFFFF_FFFF);
        cyc(1'b1, 4'd14, 32'h0);
        cyc(1'b1, 4'd15, 32'h0);
        read_at(4'd2, 32'h0000_0F0F, "R10");
        read_at(4'd14, 32'h5A5A_5A5F, "R10");
        // R8: pin level readable in every mode
        cyc(1'b0, 4'd15, '0);
        pad_in = 32'h1234_5678;
        @(negedge clk); #1;
        check("R8", "pin level", bus_rdata, 32'h1234_5678);
        // long mixed run: writes and input changes land in the same cycles
        for (int n = 0; n < 2000; n++) begin
            cyc(($urandom % 3) != 0, 4'($urandom), $urandom);
        end
        cyc(1'b0, 4'd2, '0);
        @(negedge clk); #1;
        finish_run();
    end
endmodule